// File: doc/BRIEF.md
# Periodic Countdown Timer with Interrupt Status

This block is a single countdown timer channel behind a 32-bit register bus. Software programs an interval, selects a tick source and a power-of-two prescale, and starts the channel. Each qualified tick lowers the counter by one. When the counter steps down to zero, the channel raises a pending flag. It then reloads for a periodic event, stays at zero, or stops itself in single-shot mode.

The tick sources are enable strobes that the block receives from outside. One comes from a fixed oscillator domain and the other from an alternate clock domain. A per-channel interrupt enable gates the pending flag onto a registered, level-sensitive interrupt line. Software acknowledges an event by writing a one to its pending bit.

Top module: `periodic_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register map and bus behaviour:
  - Interrupt enable is at 0x00, with bit 0 for this channel.
  - Status is at 0x04, with bit 0 as the pending flag.
  - Control is at 0x10: bit 0 run, bit 1 reload, bits 3:2 tick source, bits 6:4 prescale, bit 7 single-shot.
  - Interval is at 0x14.
  - The live count is at 0x18 and is read-only.
  - Unimplemented bits read zero.
  - Read data appears on `bus_rdata` one clock after the read request.
- R3: A control write that changes run from 0 to 1 copies the interval into the counter.
- R4: Tick source code 1 counts `tick_osc` and code 2 counts `tick_alt`. Codes 0 and 3 count nothing, and a strobe on a source that is not selected has no effect.
- R5: A prescale value p passes one of every 2^p selected strobes, so 0 passes every strobe and 7 passes every 128th.
- R6: While running, each passed tick lowers a nonzero count by one. The tick that takes the count from 1 to 0 sets pending bit 0.
- R7: With single-shot 0 and reload 1, the expiring tick loads the interval again instead of zero, so events repeat every interval ticks.
- R8: With single-shot 0 and reload 0, the counter stays at zero after expiry and no further event occurs.
- R9: With single-shot 1, the expiring tick clears the run bit and leaves the count at zero.
- R10: Writing a one to a status bit clears it, and writing a zero leaves it unchanged.
- R11: `irq` is the registered OR of status AND interrupt enable, so it follows them one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_osc | input | 1 | Oscillator tick strobe (source code 1) |
| tick_alt | input | 1 | Alternate tick strobe (source code 2) |
| irq | output | 1 | Level interrupt |

## Verification
The counter is driven from each tick source with the other source strobing as a decoy. This separates correct source selection from a design that counts any strobe, and codes 0 and 3 show that no strobe reaches the counter. Prescales 0, 2 and 7 are tried with counts that stop one strobe short of expiry. This tells an exact 2^p divider apart from an off-by-one divider or one that ignores the field. Expiry is tried in the periodic, hold-at-zero and single-shot modes, and the count, control and status are read back to tell the three reactions apart. Interrupt gating and write-one-to-clear are tried with zero and one patterns in both registers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] OFS_IEN  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_IVAL = 8'h14;
  localparam logic [7:0] OFS_CUR  = 8'h18;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_OSC  = 2'd1,
    SRC_ALT  = 2'd2,
    SRC_RSVD = 2'd3
  } tick_src_e;

  // Field order follows the control register bit layout, MSB first.
  typedef struct packed {
    logic      one_shot;
    logic [2:0] prescale;
    tick_src_e src;
    logic      reload;
    logic      run;
  } ctrl_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PRE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  tmr_pkg::tick_src_e src,
  input  logic [PRE_W-1:0]   prescale,
  input  logic               tick_osc,
  input  logic               tick_alt,
  output logic               tick_out
);
  import tmr_pkg::*;
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic             src_tick;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] mask;

  always_comb begin
    case (src)
      SRC_OSC: src_tick = tick_osc;
      SRC_ALT: src_tick = tick_alt;
      default: src_tick = 1'b0;
    endcase
  end

  assign mask = ~({DIV_W{1'b1}} << prescale);

  always_ff @(posedge clk) begin
    if (rst || !run) div_cnt <= '0;
    else if (src_tick) div_cnt <= div_cnt + 1'b1;
  end

  assign tick_out = run && src_tick && ((div_cnt & mask) == mask);
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctrl_we,
  input  tmr_pkg::ctrl_t        ctrl_wdata,
  input  logic [CNT_W-1:0]      ival,
  input  logic                  tick,
  output tmr_pkg::ctrl_t        ctrl_q,
  output logic [CNT_W-1:0]      count,
  output logic                  expire
);
  import tmr_pkg::*;

  logic hit;
  assign hit    = ctrl_q.run && tick && (count == CNT_W'(1));
  assign expire = hit && !ctrl_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      count  <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
      if (ctrl_wdata.run && !ctrl_q.run) count <= ival;
    end else if (hit) begin
      if (ctrl_q.one_shot) begin
        count      <= '0;
        ctrl_q.run <= 1'b0;
      end else if (ctrl_q.reload) begin
        count <= ival;
      end else begin
        count <= '0;
      end
    end else if (ctrl_q.run && tick && count != '0) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int NCH = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ien_we,
  input  logic           stat_we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] evt,
  output logic [NCH-1:0] ien,
  output logic [NCH-1:0] status,
  output logic           irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else if (evt[i]) status[i] <= 1'b1;
      else if (stat_we && wdata[i]) status[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      irq <= 1'b0;
    end else begin
      if (ien_we) ien <= wdata;
      irq <= |(status & ien);
    end
  end
endmodule

// File: rtl/periodic_timer.sv
module periodic_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 3,
  parameter int NCH    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_osc,
  input  logic              tick_alt,
  output logic              irq
);
  import tmr_pkg::*;
  localparam int CTRL_W = $bits(ctrl_t);

  logic             wr_cyc, rd_cyc;
  logic [CNT_W-1:0] ival_q, count_q;
  ctrl_t            ctrl_q;
  logic             tick_en, expire;
  logic [NCH-1:0]   ien_q, stat_q, evt;

  assign wr_cyc = bus_sel && bus_wr;
  assign rd_cyc = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (rst) ival_q <= '0;
    else if (wr_cyc && bus_addr == OFS_IVAL) ival_q <= bus_wdata[CNT_W-1:0];
  end

  tmr_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .src(ctrl_q.src),
    .prescale(PRE_W'(ctrl_q.prescale)), .tick_osc(tick_osc),
    .tick_alt(tick_alt), .tick_out(tick_en)
  );

  tmr_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .ctrl_we(wr_cyc && bus_addr == OFS_CTRL),
    .ctrl_wdata(ctrl_t'(bus_wdata[CTRL_W-1:0])),
    .ival(ival_q), .tick(tick_en), .ctrl_q(ctrl_q),
    .count(count_q), .expire(expire)
  );

  always_comb begin
    evt    = '0;
    evt[0] = expire;
  end

  tmr_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst),
    .ien_we(wr_cyc && bus_addr == OFS_IEN),
    .stat_we(wr_cyc && bus_addr == OFS_STAT),
    .wdata(bus_wdata[NCH-1:0]), .evt(evt),
    .ien(ien_q), .status(stat_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_cyc) begin
      case (bus_addr)
        OFS_IEN:  bus_rdata <= DATA_W'(ien_q);
        OFS_STAT: bus_rdata <= DATA_W'(stat_q);
        OFS_CTRL: bus_rdata <= DATA_W'(ctrl_q);
        OFS_IVAL: bus_rdata <= DATA_W'(ival_q);
        OFS_CUR:  bus_rdata <= DATA_W'(count_q);
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32,
  parameter int NCH   = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [7:0]       ctrl,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic [NCH-1:0]   status,
  input logic [NCH-1:0]   ien,
  input logic             irq
);
  logic wr;
  assign wr = bus_sel && bus_wr;

  // R11: interrupt only after an enabled pending flag
  assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status & ien)));

  // R6: count stays put without a tick or a write
  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(count));

  // R6: step from 1 to 0 raises pending
  assert_expire_pend_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && tick && count == CNT_W'(1) && !wr) |=> status[0]);

  // R6: pending rises only on an expiring tick
  assert_pend_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> $past(ctrl[0] && tick && count == CNT_W'(1)));

  // R9: single-shot expiry stops the channel at zero
  assert_one_shot_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && ctrl[7] && tick && count == CNT_W'(1) && !wr)
      |=> (!ctrl[0] && count == '0));
endmodule

bind periodic_timer tmr_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .ctrl(ctrl_q), .count(count_q), .tick(tick_en),
  .status(stat_q), .ien(ien_q), .irq(irq)
);

// File: tb/test_periodic_timer.sv
module test_periodic_timer;
  logic        clk = 0, rst = 1;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        tick_osc = 0, tick_alt = 0, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_due = 0;

  periodic_timer i_periodic_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_osc(tick_osc), .tick_alt(tick_alt), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) rd_due <= bus_sel & ~bus_wr;

  // Monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_due) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic osc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_osc = 1;
      @(negedge clk) tick_osc = 0;
    end
  endtask

  task automatic alt(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_alt = 1;
      @(negedge clk) tick_alt = 0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd(8'h00, 0, "R1 ien");
    rd(8'h04, 0, "R1 status");
    rd(8'h10, 0, "R1 ctrl");
    rd(8'h14, 0, "R1 interval");
    rd(8'h18, 0, "R1 count");
    chk_irq(0, "R1 irq");

    // Periodic run from the oscillator source
    wr(8'h14, 5);
    wr(8'h10, 32'h07);
    rd(8'h10, 32'h07, "R2 ctrl readback");
    rd(8'h18, 5, "R3 load on run rise");
    alt(4);
    rd(8'h18, 5, "R4 unselected source ignored");
    osc(3);
    rd(8'h18, 2, "R6 decrement");
    osc(1);
    rd(8'h04, 0, "R6 no pending before zero");
    osc(1);
    rd(8'h04, 1, "R6 pending at zero");
    rd(8'h18, 5, "R7 periodic reload");
    chk_irq(0, "R11 gated by enable");
    wr(8'h00, 32'hFFFF_FFFF);
    chk_irq(1, "R11 irq asserted");
    rd(8'h00, 1, "R2 unused ien bits");
    wr(8'h18, 32'h1234);
    rd(8'h18, 5, "R2 count read-only");
    wr(8'h04, 0);
    rd(8'h04, 1, "R10 write zero keeps");
    wr(8'h04, 1);
    rd(8'h04, 0, "R10 write one clears");
    chk_irq(0, "R11 irq drops");

    // Prescale 2 on the alternate source
    wr(8'h10, 0);
    wr(8'h14, 3);
    wr(8'h10, 32'h2B);
    osc(4);
    alt(11);
    rd(8'h18, 1, "R5 div4 count");
    rd(8'h04, 0, "R5 div4 no early event");
    alt(1);
    rd(8'h04, 1, "R5 div4 event");
    rd(8'h18, 3, "R7 reload after prescale");
    wr(8'h04, 1);

    // Prescale 7
    wr(8'h10, 0);
    wr(8'h14, 1);
    wr(8'h10, 32'h77);
    osc(127);
    rd(8'h04, 0, "R5 div128 not yet");
    osc(1);
    rd(8'h04, 1, "R5 div128 event");
    wr(8'h04, 1);

    // Single-shot
    wr(8'h10, 0);
    wr(8'h14, 2);
    wr(8'h10, 32'h85);
    osc(2);
    rd(8'h04, 1, "R9 event");
    rd(8'h10, 32'h84, "R9 run cleared");
    rd(8'h18, 0, "R9 count zero");
    wr(8'h04, 1);
    osc(3);
    rd(8'h18, 0, "R9 stays stopped");
    rd(8'h04, 0, "R9 no repeat");

    // Continuous mode without reload
    wr(8'h10, 0);
    wr(8'h14, 2);
    wr(8'h10, 32'h05);
    osc(2);
    rd(8'h04, 1, "R8 event");
    rd(8'h18, 0, "R8 hold zero");
    rd(8'h10, 32'h05, "R8 still running");
    wr(8'h04, 1);
    osc(3);
    rd(8'h04, 0, "R8 no further event");
    rd(8'h18, 0, "R8 count stays zero");

    // Source codes 3 and 0 count nothing
    wr(8'h10, 0);
    wr(8'h14, 4);
    wr(8'h10, 32'h0F);
    osc(2); alt(2);
    rd(8'h18, 4, "R4 code 3 idle");
    wr(8'h10, 0);
    wr(8'h10, 32'h03);
    osc(2); alt(2);
    rd(8'h18, 4, "R4 code 0 idle");
    chk_irq(0, "R11 idle");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: got %0d unanswered reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule